// File: doc/BRIEF.md
# Microprogram Sequencer with Opcode Mapper

This block steps a microprogrammed control unit through its control store. It asks for an instruction through a request/acknowledge handshake, turns the 16-bit instruction into a starting micro-address, and then issues one control word per cycle from an internal microcode table. Each control word carries a completion bit. When that bit is set, the sequencer returns to fetching. When it is clear, the micro-address advances by one and the next word is issued.

Instruction fetch is done by the sequencer hardware, so no microcode is spent on it. The datapath sees only the control word, a valid strobe and the current micro-address. An instruction whose top nibble is 0 and whose second nibble is F stops the sequencer until reset.

The memory-source field of a control word must select at most one source. A word that selects more than one source raises an error flag and has its source field cleared. The table built in here is a small test program.

Top module: `useq_sequencer`

## Requirements
- R1: Synchronous active-high reset puts the block in fetch with uaddr 0. While `rst` is held and right after it is released, fetch_req is 1 and ctrl_valid, ctrl_word, src_err and halted are all 0.
- R2: A fetch completes on a clock edge where fetch_req and fetch_ack are both high. In the next cycle ctrl_valid is 1 and uaddr holds the mapped start address. While fetch_ack stays low, fetch_req stays high and uaddr does not change.
- R3: When the top nibble is 1..7, bit 15 = 0 selects the direct start address and bits 14..12 give the opcode. When the top nibble is 9..F, bit 15 = 1 selects the indirect start address. Bits 11..0 are ignored. The pairs (direct/indirect) are: op1 03/17, op2 05/1A, op3 07/1D, op4 09/21, op5 0C/24, op6 0F/27, op7 12/2A.
- R4: When the top nibble is 0, the start address depends on sub-opcode bits 11..8 (0..E), in this order: 30,32,34,4A,36,9A,46,3C,38,3A,3E,40,48,42,44.
- R5: When the top nibble is 8, the start address depends on sub-opcode bits 11..8 (0..F), in this order: 70,73,75,7C,79,7F,84,87,89,8B,8D,8F,91,94,96,98.
- R6: Bit 0 of the control word marks the end of the instruction. If it is 1, the next cycle has fetch_req = 1 and ctrl_valid = 0. If it is 0, the next cycle issues the word at uaddr+1.
- R7: An all-zero control word is issued as zero, and the only thing it does is advance uaddr by one.
- R8: Control-word bits 3..1 are the memory-source select (bit1 instruction, bit2 address, bit3 program counter). If more than one of these bits is set, src_err is 1 for that cycle and those bits are output as 0. All other bits pass through unchanged.
- R9: An instruction with top nibble 0 and sub-opcode F sets halted = 1 in the next cycle. It also drops fetch_req and ctrl_valid, sets uaddr to 00, and stays in that state, ignoring fetch_ack, until reset.
- R10: The control-word layout is: bits 23..6 operation, bit 5 new interrupt-enable value, bit 4 interrupt-enable change, bits 3..1 source, bit 0 end. The table contents are: 03:000042 04:000081 17:0000C2 18:000105 30:000000 31:000141 46:000186 47:0001C1 70:000008 71:000000 72:000201 96:000031 98:000011. Every other address holds 000001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_ack | input | 1 | Instruction word is valid on `instr` |
| instr | input | 16 | Fetched instruction word |
| fetch_req | output | 1 | Sequencer wants the next instruction |
| ctrl_valid | output | 1 | `ctrl_word` is live this cycle |
| ctrl_word | output | 24 | Current control word, zero when not valid |
| uaddr | output | 8 | Control address register |
| src_err | output | 1 | Current word selected more than one memory source |
| halted | output | 1 | Halt instruction reached |

## Verification
The hardest conditions to reach from the ports are an instruction that is partway through a multi-step sequence and the rejection of a multi-source word. Each depends on particular table addresses being entered through the mapper. The stimulus gets there with chosen opcodes: push runs three steps and is interrupted by reset midway, compare reaches the word with two source bits set, and load-from-data passes through the all-zero word. Halt is checked last under repeated acknowledges to show that it holds.

// File: rtl/useq_pkg.sv
package useq_pkg;

    localparam int IW_W  = 16;
    localparam int UA_W  = 8;
    localparam int CW_W  = 24;
    localparam int OP_W  = CW_W - 6;
    localparam int SRC_W = 3;

    typedef struct packed {
        logic [OP_W-1:0]  op;
        logic             ie_val;
        logic             ie_chg;
        logic [SRC_W-1:0] src;
        logic             last;
    } cw_t;

    typedef enum logic [1:0] {
        S_FETCH = 2'd0,
        S_EXEC  = 2'd1,
        S_HALT  = 2'd2
    } seq_state_t;

    // start address for an instruction that carries an address operand
    function automatic logic [UA_W-1:0] map_operand(input logic [2:0] opc, input logic ind);
        logic [UA_W-1:0] d, i;
        case (opc)
            3'd1:    begin d = 8'h03; i = 8'h17; end
            3'd2:    begin d = 8'h05; i = 8'h1A; end
            3'd3:    begin d = 8'h07; i = 8'h1D; end
            3'd4:    begin d = 8'h09; i = 8'h21; end
            3'd5:    begin d = 8'h0C; i = 8'h24; end
            3'd6:    begin d = 8'h0F; i = 8'h27; end
            default: begin d = 8'h12; i = 8'h2A; end
        endcase
        return ind ? i : d;
    endfunction

    function automatic logic [UA_W-1:0] map_alu(input logic [3:0] sub);
        case (sub)
            4'h0: return 8'h30;  4'h1: return 8'h32;
            4'h2: return 8'h34;  4'h3: return 8'h4A;
            4'h4: return 8'h36;  4'h5: return 8'h9A;
            4'h6: return 8'h46;  4'h7: return 8'h3C;
            4'h8: return 8'h38;  4'h9: return 8'h3A;
            4'hA: return 8'h3E;  4'hB: return 8'h40;
            4'hC: return 8'h48;  4'hD: return 8'h42;
            4'hE: return 8'h44;  default: return 8'h00;
        endcase
    endfunction

    function automatic logic [UA_W-1:0] map_misc(input logic [3:0] sub);
        case (sub)
            4'h0: return 8'h70;  4'h1: return 8'h73;
            4'h2: return 8'h75;  4'h3: return 8'h7C;
            4'h4: return 8'h79;  4'h5: return 8'h7F;
            4'h6: return 8'h84;  4'h7: return 8'h87;
            4'h8: return 8'h89;  4'h9: return 8'h8B;
            4'hA: return 8'h8D;  4'hB: return 8'h8F;
            4'hC: return 8'h91;  4'hD: return 8'h94;
            4'hE: return 8'h96;  default: return 8'h98;
        endcase
    endfunction

    // built-in test microprogram
    function automatic cw_t ucode_word(input logic [UA_W-1:0] a);
        logic [CW_W-1:0] w;
        case (a)
            8'h03:   w = 24'h000042;
            8'h04:   w = 24'h000081;
            8'h17:   w = 24'h0000C2;
            8'h18:   w = 24'h000105;
            8'h30:   w = 24'h000000;
            8'h31:   w = 24'h000141;
            8'h46:   w = 24'h000186;
            8'h47:   w = 24'h0001C1;
            8'h70:   w = 24'h000008;
            8'h71:   w = 24'h000000;
            8'h72:   w = 24'h000201;
            8'h96:   w = 24'h000031;
            8'h98:   w = 24'h000011;
            default: w = 24'h000001;
        endcase
        return cw_t'(w);
    endfunction

endpackage

// File: rtl/useq_mapper.sv
module useq_mapper
    import useq_pkg::*;
(
    input  logic [IW_W-1:0] instr,
    output logic [UA_W-1:0] start_ua,
    output logic            is_halt
);
    logic [3:0] top_nib;
    logic [3:0] sub_nib;
    logic       unused_low;

    assign top_nib    = instr[15:12];
    assign sub_nib    = instr[11:8];
    assign unused_low = ^instr[7:0];

    always_comb begin
        case (top_nib)
            4'h0:    start_ua = map_alu(sub_nib);
            4'h8:    start_ua = map_misc(sub_nib);
            default: start_ua = map_operand(instr[14:12], instr[15]);
        endcase
    end

    assign is_halt = (top_nib == 4'h0) && (sub_nib == 4'hF);

endmodule

// File: rtl/useq_rom.sv
module useq_rom
    import useq_pkg::*;
#(
    parameter int DEPTH = 1 << UA_W
) (
    input  logic [UA_W-1:0] ua,
    output cw_t             word
);
    cw_t table_w [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_word
        assign table_w[g] = ucode_word(UA_W'(g));
    end

    assign word = table_w[ua];

endmodule

// File: rtl/useq_srcchk.sv
module useq_srcchk
    import useq_pkg::*;
(
    input  cw_t  raw,
    output cw_t  clean,
    output logic multi
);
    always_comb begin
        multi = (raw.src & (raw.src - 1'b1)) != '0;
        clean = raw;
        if (multi) begin
            clean.src = '0;
        end
    end

endmodule

// File: rtl/useq_sequencer.sv
module useq_sequencer
    import useq_pkg::*;
#(
    parameter int DEPTH = 1 << UA_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            fetch_ack,
    input  logic [IW_W-1:0] instr,
    output logic            fetch_req,
    output logic            ctrl_valid,
    output logic [CW_W-1:0] ctrl_word,
    output logic [UA_W-1:0] uaddr,
    output logic            src_err,
    output logic            halted
);
    seq_state_t      st;
    logic [UA_W-1:0] car;
    logic [UA_W-1:0] map_ua;
    logic            map_halt;
    cw_t             cw_raw;
    cw_t             cw_clean;
    logic            cw_multi;

    useq_mapper u_map (
        .instr    (instr),
        .start_ua (map_ua),
        .is_halt  (map_halt)
    );

    useq_rom #(.DEPTH(DEPTH)) u_rom (
        .ua   (car),
        .word (cw_raw)
    );

    useq_srcchk u_chk (
        .raw   (cw_raw),
        .clean (cw_clean),
        .multi (cw_multi)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= S_FETCH;
            car <= '0;
        end else begin
            case (st)
                S_FETCH: if (fetch_ack) begin
                    car <= map_ua;
                    st  <= map_halt ? S_HALT : S_EXEC;
                end
                S_EXEC: begin
                    if (cw_raw.last) st <= S_FETCH;
                    else             car <= car + 1'b1;
                end
                S_HALT:  st <= S_HALT;
                default: st <= S_FETCH;
            endcase
        end
    end

    assign fetch_req  = (st == S_FETCH);
    assign ctrl_valid = (st == S_EXEC);
    assign halted     = (st == S_HALT);
    assign uaddr      = car;
    assign ctrl_word  = ctrl_valid ? CW_W'(cw_clean) : '0;
    assign src_err    = ctrl_valid & cw_multi;

    // R2: accepted fetch lands on the mapper's start address
    p_fetch_map_r2: assert property (@(posedge clk) disable iff (rst)
        fetch_req && fetch_ack && !map_halt |=> ctrl_valid && uaddr == $past(map_ua));

    // R6: end bit returns to fetch
    p_end_fetch_r6: assert property (@(posedge clk) disable iff (rst)
        ctrl_valid && cw_raw.last |=> fetch_req && !ctrl_valid);

    // R6/R7: non-final word steps the address by one
    p_step_r7: assert property (@(posedge clk) disable iff (rst)
        ctrl_valid && !cw_raw.last |=> ctrl_valid && uaddr == $past(uaddr) + 8'd1);

    // R8: issued source field never selects two sources
    p_src_onehot_r8: assert property (@(posedge clk) disable iff (rst)
        ctrl_valid |-> $onehot0(ctrl_word[3:1]));

    // R8: an error cycle carries an empty source field
    p_err_clear_r8: assert property (@(posedge clk) disable iff (rst)
        src_err |-> ctrl_word[3:1] == 3'b000 && ctrl_valid);

    // R9: halt is sticky and silent
    p_halt_hold_r9: assert property (@(posedge clk) disable iff (rst)
        halted |=> halted && !fetch_req && !ctrl_valid && $stable(uaddr));

endmodule

// File: tb/tb_useq_sequencer.sv
`timescale 1ns/1ps
module tb_useq_sequencer;

    logic        clk = 1'b0;
    logic        rst;
    logic        fetch_ack;
    logic [15:0] instr;
    logic        fetch_req;
    logic        ctrl_valid;
    logic [23:0] ctrl_word;
    logic [7:0]  uaddr;
    logic        src_err;
    logic        halted;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    useq_sequencer dut (
        .clk        (clk),
        .rst        (rst),
        .fetch_ack  (fetch_ack),
        .instr      (instr),
        .fetch_req  (fetch_req),
        .ctrl_valid (ctrl_valid),
        .ctrl_word  (ctrl_word),
        .uaddr      (uaddr),
        .src_err    (src_err),
        .halted     (halted)
    );

    // {instr, start, first word, steps}
    localparam logic [51:0] VEC [45] = '{
        {16'h1A5C, 8'h03, 24'h000042, 4'd2}, {16'h9A5C, 8'h17, 24'h0000C2, 4'd2},
        {16'h2123, 8'h05, 24'h000001, 4'd1}, {16'hA123, 8'h1A, 24'h000001, 4'd1},
        {16'h3FFF, 8'h07, 24'h000001, 4'd1}, {16'hBFFF, 8'h1D, 24'h000001, 4'd1},
        {16'h4000, 8'h09, 24'h000001, 4'd1}, {16'hC000, 8'h21, 24'h000001, 4'd1},
        {16'h5777, 8'h0C, 24'h000001, 4'd1}, {16'hD777, 8'h24, 24'h000001, 4'd1},
        {16'h6ABC, 8'h0F, 24'h000001, 4'd1}, {16'hEABC, 8'h27, 24'h000001, 4'd1},
        {16'h7001, 8'h12, 24'h000001, 4'd1}, {16'hF001, 8'h2A, 24'h000001, 4'd1},
        {16'h00AA, 8'h30, 24'h000000, 4'd2}, {16'h01AA, 8'h32, 24'h000001, 4'd1},
        {16'h02AA, 8'h34, 24'h000001, 4'd1}, {16'h03AA, 8'h4A, 24'h000001, 4'd1},
        {16'h04AA, 8'h36, 24'h000001, 4'd1}, {16'h05AA, 8'h9A, 24'h000001, 4'd1},
        {16'h06AA, 8'h46, 24'h000180, 4'd2}, {16'h07AA, 8'h3C, 24'h000001, 4'd1},
        {16'h08AA, 8'h38, 24'h000001, 4'd1}, {16'h09AA, 8'h3A, 24'h000001, 4'd1},
        {16'h0AAA, 8'h3E, 24'h000001, 4'd1}, {16'h0BAA, 8'h40, 24'h000001, 4'd1},
        {16'h0CAA, 8'h48, 24'h000001, 4'd1}, {16'h0DAA, 8'h42, 24'h000001, 4'd1},
        {16'h0EAA, 8'h44, 24'h000001, 4'd1},
        {16'h8055, 8'h70, 24'h000008, 4'd3}, {16'h8155, 8'h73, 24'h000001, 4'd1},
        {16'h8255, 8'h75, 24'h000001, 4'd1}, {16'h8355, 8'h7C, 24'h000001, 4'd1},
        {16'h8455, 8'h79, 24'h000001, 4'd1}, {16'h8555, 8'h7F, 24'h000001, 4'd1},
        {16'h8655, 8'h84, 24'h000001, 4'd1}, {16'h8755, 8'h87, 24'h000001, 4'd1},
        {16'h8855, 8'h89, 24'h000001, 4'd1}, {16'h8955, 8'h8B, 24'h000001, 4'd1},
        {16'h8A55, 8'h8D, 24'h000001, 4'd1}, {16'h8B55, 8'h8F, 24'h000001, 4'd1},
        {16'h8C55, 8'h91, 24'h000001, 4'd1}, {16'h8D55, 8'h94, 24'h000001, 4'd1},
        {16'h8E55, 8'h96, 24'h000031, 4'd1}, {16'h8F55, 8'h98, 24'h000011, 4'd1}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // present one instruction; returns at the negedge after the accepting edge
    task automatic do_fetch(input logic [15:0] w);
        instr     = w;
        fetch_ack = 1'b1;
        @(negedge clk);
        fetch_ack = 1'b0;
    endtask

    task automatic check_reset_state(input string tag);
        chk({tag, " fetch_req"},  32'(fetch_req),  32'd1);
        chk({tag, " ctrl_valid"}, 32'(ctrl_valid), 32'd0);
        chk({tag, " ctrl_word"},  32'(ctrl_word),  32'd0);
        chk({tag, " uaddr"},      32'(uaddr),      32'd0);
        chk({tag, " src_err"},    32'(src_err),    32'd0);
        chk({tag, " halted"},     32'(halted),     32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst       = 1'b1;
        fetch_ack = 1'b0;
        instr     = 16'h0000;
        repeat (3) @(negedge clk);
        check_reset_state("R1 held");
        rst = 1'b0;
        check_reset_state("R1 released");

        // R2: no acknowledge, nothing moves
        repeat (4) @(negedge clk);
        chk("R2 idle fetch_req", 32'(fetch_req), 32'd1);
        chk("R2 idle uaddr", 32'(uaddr), 32'd0);
        chk("R2 idle ctrl_valid", 32'(ctrl_valid), 32'd0);

        // table walk: R3/R4/R5 start address, R10 first word, R6 step count
        for (int k = 0; k < 45; k++) begin
            logic [15:0] w;
            logic [7:0]  s;
            logic [23:0] fw;
            logic [3:0]  ns;
            int          n;
            string       rq;
            {w, s, fw, ns} = VEC[k];
            rq = (k < 14) ? "R3" : ((k < 29) ? "R4" : "R5");
            do_fetch(w);
            chk({rq, " R2 start address"}, 32'(uaddr), 32'(s));
            chk("R10 first word", 32'(ctrl_word), 32'(fw));
            n = 0;
            while (ctrl_valid && n < 10) begin
                n++;
                @(negedge clk);
            end
            chk("R6 steps", 32'(n), 32'(ns));
            chk("R6 back to fetch", 32'(fetch_req), 32'd1);
        end

        // R7: all-zero word only advances the address
        do_fetch(16'h0000);
        chk("R7 zero word", 32'(ctrl_word), 32'd0);
        chk("R7 zero word valid", 32'(ctrl_valid), 32'd1);
        @(negedge clk);
        chk("R7 advanced uaddr", 32'(uaddr), 32'h31);
        chk("R7 next word", 32'(ctrl_word), 32'h000141);
        @(negedge clk);

        // R8: multi-source word flagged and cleared
        do_fetch(16'h0600);
        chk("R8 src_err set", 32'(src_err), 32'd1);
        chk("R8 source cleared", 32'(ctrl_word), 32'h000180);
        @(negedge clk);
        chk("R8 src_err clear", 32'(src_err), 32'd0);
        chk("R8 following word", 32'(ctrl_word), 32'h0001C1);
        @(negedge clk);

        // R8: a single source passes through
        do_fetch(16'h9000);
        chk("R8 single source kept", 32'(ctrl_word), 32'h0000C2);
        chk("R8 no error", 32'(src_err), 32'd0);
        repeat (2) @(negedge clk);

        // R1: reset in the middle of a three-step push
        do_fetch(16'h8000);
        @(negedge clk);
        chk("R7 push mid uaddr", 32'(uaddr), 32'h71);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check_reset_state("R1 mid");

        // R9: halt and hold under further acknowledges
        do_fetch(16'h0F55);
        chk("R9 halted", 32'(halted), 32'd1);
        chk("R9 fetch_req", 32'(fetch_req), 32'd0);
        chk("R9 ctrl_valid", 32'(ctrl_valid), 32'd0);
        chk("R9 uaddr", 32'(uaddr), 32'h00);
        instr     = 16'h1234;
        fetch_ack = 1'b1;
        repeat (3) @(negedge clk);
        fetch_ack = 1'b0;
        chk("R9 still halted", 32'(halted), 32'd1);
        chk("R9 uaddr held", 32'(uaddr), 32'h00);
        chk("R9 word zero", 32'(ctrl_word), 32'd0);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check_reset_state("R1 after halt");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule